// File: doc/BRIEF.md
# Pointer Load/Store Address Generator

This block turns one indirect or direct data-memory transfer request into a single access on a synchronous byte memory. It also keeps the three 16-bit address pointers that indirect transfers use. In this text the pointers are called X, Y and Z. Five addressing forms are available:

- **Plain:** the selected pointer is used as the address and is left unchanged.
- **Post-increment:** the old pointer value is used as the address, and the pointer then advances by one.
- **Pre-decrement:** the pointer steps down by one first, and the new value is used as the address.
- **Offset:** a 6-bit unsigned offset is added to Y or Z, and the pointer is left unchanged.
- **Absolute:** a 16-bit immediate address is used, and no pointer is touched.

A load returns the fetched byte on a register-file write port. A store drives the byte that came with the request.

Every transfer uses exactly two cycles. In the first cycle `busy` is high and the memory is driven. In the second cycle `done` pulses, load data goes to the register port, and any pointer change is already visible on the pointer outputs. A new request may arrive in that second cycle, so the block can accept one transfer every two cycles. A separate load port sets any pointer to a chosen value while the block is idle. A request that has no meaning (an offset on X, pointer select 3, or an unknown mode code) is still completed. It uses the same two cycles, but performs no memory access and changes no pointer. `illegal` is raised together with `done`. The block has no status flags, and no transfer changes any flag.

Top module: `ptr_agu`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all pointers read 0 and `busy`, `done`, `illegal`, `mem_re`, `mem_we` and `rf_we` are low.
- R2: A request is accepted at a rising clock edge when `req_valid` is 1, `busy` is 0 and `ptr_load` is 0. After acceptance, `busy` is high for exactly one cycle and `done` is high for exactly the cycle after that. `req_valid` is ignored while `busy` is high.
- R3: Mode 0 (plain) addresses the selected pointer and leaves it unchanged. Pointer select codes are 0 = X, 1 = Y and 2 = Z.
- R4: Mode 1 (post-increment) addresses the pointer's old value. In the done cycle the pointer reads old + 1 modulo 2^16.
- R5: Mode 2 (pre-decrement) addresses old − 1 modulo 2^16, and the pointer holds that same value in the done cycle.
- R6: Mode 3 (offset) on Y or Z addresses pointer + `req_disp`, modulo 2^16. `req_disp` is an unsigned value from 0 to 63. The pointer is left unchanged.
- R7: Mode 4 (absolute) addresses `req_imm` and leaves all three pointers unchanged.
- R8: Three kinds of request are illegal: mode 3 with select 0, select code 3, and mode codes 5 to 7. An illegal request drives neither `mem_re` nor `mem_we` and changes no pointer. It still completes with `done` and `illegal` high together, and `rf_we` stays low.
- R9: A store (`req_store` = 1) raises `mem_we` in the busy cycle, with `mem_wdata` equal to the request's `req_wdata`. A store never raises `rf_we`.
- R10: A load (`req_store` = 0) raises `mem_re` in the busy cycle. In the done cycle it raises `rf_we`, with `rf_waddr` equal to `req_reg` and `rf_wdata` equal to the byte the memory returned.
- R11: `ptr_load` in a non-busy cycle writes `ptr_load_val` into the pointer chosen by `ptr_load_sel`; select code 3 writes nothing. In the same cycle, `ptr_load` takes priority over `req_valid`, and that request is dropped. `ptr_load` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| req_mode | input | 3 | 0 plain, 1 post-inc, 2 pre-dec, 3 offset, 4 absolute |
| req_disp | input | 6 | Unsigned offset for mode 3 |
| req_imm | input | 16 | Absolute address for mode 4 |
| req_wdata | input | 8 | Store data |
| req_reg | input | 5 | Destination register index for a load |
| ptr_load | input | 1 | Pointer initialisation strobe |
| ptr_load_sel | input | 2 | Pointer to initialise |
| ptr_load_val | input | 16 | Value written by `ptr_load` |
| busy | output | 1 | High in the access cycle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed request was illegal (with `done`) |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 8 | Register write data |
| ptr_x | output | 16 | Current X pointer |
| ptr_y | output | 16 | Current Y pointer |
| ptr_z | output | 16 | Current Z pointer |

## Verification
The assertions assume the following about the block's surroundings:
- All request and load inputs are free of X at each clock edge.
- The memory delivers read data exactly one cycle after `mem_re`.
- Nothing outside the block changes the pointers.

The bench memory captures the strobes at mid-cycle and answers at the next edge, which meets the one-cycle read timing. All inputs change just after a rising edge. The random phase draws select and mode codes over their full ranges, so illegal combinations, held requests, loads during busy cycles, and loads that collide with requests all occur while every input stays defined.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_DIRECT  = 3'd4
  } amode_e;

  localparam logic [1:0] PSEL_X = 2'd0;
  localparam logic [1:0] PSEL_Y = 2'd1;
  localparam logic [1:0] PSEL_Z = 2'd2;
endpackage

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc
  import ptr_agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    sel,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] ptr_cur,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] ptr_next,
  output logic          ptr_wr,
  output logic          bad
);
  localparam int PADW = AW - QW;

  function automatic logic [AW-1:0] step_ptr(input logic [2:0] m, input logic [AW-1:0] p);
    logic [AW-1:0] r;
    case (m)
      AM_POSTINC: r = p + AW'(1);
      AM_PREDEC:  r = p - AW'(1);
      default:    r = p;
    endcase
    return r;
  endfunction

  function automatic logic [AW-1:0] pick_addr(input logic [2:0] m, input logic [AW-1:0] p,
                                              input logic [QW-1:0] q, input logic [AW-1:0] k);
    logic [AW-1:0] r;
    case (m)
      AM_PREDEC: r = p - AW'(1);
      AM_DISP:   r = p + {{PADW{1'b0}}, q};
      AM_DIRECT: r = k;
      default:   r = p;
    endcase
    return r;
  endfunction

  function automatic logic is_bad(input logic [2:0] m, input logic [1:0] s);
    logic r;
    r = (m > AM_DIRECT) || (s == 2'd3) || ((m == AM_DISP) && (s == PSEL_X));
    return r;
  endfunction

  always_comb begin
    acc_addr = pick_addr(mode, ptr_cur, disp, imm);
    ptr_next = step_ptr(mode, ptr_cur);
    ptr_wr   = (mode == AM_POSTINC) || (mode == AM_PREDEC);
    bad      = is_bad(mode, sel);
  end
endmodule

// File: rtl/ptr_agu_ptrs.sv
module ptr_agu_ptrs #(
  parameter int AW   = 16,
  parameter int NPTR = 3,
  parameter int SW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [SW-1:0]            ld_sel,
  input  logic [AW-1:0]            ld_val,
  input  logic                     upd_en,
  input  logic [SW-1:0]            upd_sel,
  input  logic [AW-1:0]            upd_val,
  output logic [NPTR-1:0][AW-1:0]  ptrs
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic hit_ld, hit_upd;
    assign hit_ld  = ld_en  && (ld_sel  == SW'(i));
    assign hit_upd = upd_en && (upd_sel == SW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptrs[i] <= '0;
      else if (hit_upd) ptrs[i] <= upd_val;
      else if (hit_ld)  ptrs[i] <= ld_val;
    end
  end

  // R11
  ld_upd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ld_en && upd_en));
endmodule

// File: rtl/ptr_agu_seq.sv
module ptr_agu_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 5,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_store,
  input  logic          in_bad,
  input  logic          in_ptr_wr,
  input  logic [SW-1:0] in_sel,
  input  logic [AW-1:0] in_addr,
  input  logic [AW-1:0] in_ptr_next,
  input  logic [DW-1:0] in_wdata,
  input  logic [RW-1:0] in_reg,
  output logic          busy,
  output logic          done,
  output logic          bad_done,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic          upd_en,
  output logic [SW-1:0] upd_sel,
  output logic [AW-1:0] upd_val
);
  logic          st_acc, st_done;
  logic          r_store, r_bad, r_ptr_wr;
  logic [SW-1:0] r_sel;
  logic [AW-1:0] r_addr, r_ptr_next;
  logic [DW-1:0] r_wdata;
  logic [RW-1:0] r_reg;
  logic          r_load_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_acc    <= 1'b0;
      st_done   <= 1'b0;
      r_load_ok <= 1'b0;
    end else begin
      st_acc    <= start;
      st_done   <= st_acc;
      r_load_ok <= st_acc && !r_bad && !r_store;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_store    <= 1'b0;
      r_bad      <= 1'b0;
      r_ptr_wr   <= 1'b0;
      r_sel      <= '0;
      r_addr     <= '0;
      r_ptr_next <= '0;
      r_wdata    <= '0;
      r_reg      <= '0;
    end else if (start) begin
      r_store    <= in_store;
      r_bad      <= in_bad;
      r_ptr_wr   <= in_ptr_wr;
      r_sel      <= in_sel;
      r_addr     <= in_addr;
      r_ptr_next <= in_ptr_next;
      r_wdata    <= in_wdata;
      r_reg      <= in_reg;
    end
  end

  assign busy      = st_acc;
  assign done      = st_done;
  assign bad_done  = st_done && r_bad;
  assign mem_re    = st_acc && !r_bad && !r_store;
  assign mem_we    = st_acc && !r_bad && r_store;
  assign mem_addr  = r_addr;
  assign mem_wdata = r_wdata;
  assign rf_we     = st_done && r_load_ok;
  assign rf_waddr  = r_reg;
  assign upd_en    = st_acc && !r_bad && r_ptr_wr;
  assign upd_sel   = r_sel;
  assign upd_val   = r_ptr_next;

  // R2
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n) st_acc |=> !st_acc);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) st_acc |=> st_done);
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int QW = 6,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_sel,
  input  logic [2:0]    req_mode,
  input  logic [QW-1:0] req_disp,
  input  logic [AW-1:0] req_imm,
  input  logic [DW-1:0] req_wdata,
  input  logic [RW-1:0] req_reg,
  input  logic          ptr_load,
  input  logic [1:0]    ptr_load_sel,
  input  logic [AW-1:0] ptr_load_val,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic [AW-1:0] ptr_x,
  output logic [AW-1:0] ptr_y,
  output logic [AW-1:0] ptr_z
);
  localparam int NPTR = 3;
  localparam int SW   = 2;

  logic [NPTR-1:0][AW-1:0] ptrs;
  logic [AW-1:0] sel_ptr, c_addr, c_next;
  logic          c_wr, c_bad;
  logic          start, ld_go;
  logic          upd_en;
  logic [SW-1:0] upd_sel;
  logic [AW-1:0] upd_val;

  assign ld_go   = ptr_load && !busy;
  assign start   = req_valid && !busy && !ptr_load;
  assign sel_ptr = (req_sel == 2'd3) ? '0 : ptrs[req_sel];

  ptr_agu_calc #(.AW(AW), .QW(QW)) u_calc (
    .mode(req_mode), .sel(req_sel), .disp(req_disp), .imm(req_imm),
    .ptr_cur(sel_ptr), .acc_addr(c_addr), .ptr_next(c_next),
    .ptr_wr(c_wr), .bad(c_bad)
  );

  ptr_agu_seq #(.AW(AW), .DW(DW), .RW(RW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_store(req_store), .in_bad(c_bad), .in_ptr_wr(c_wr), .in_sel(req_sel),
    .in_addr(c_addr), .in_ptr_next(c_next), .in_wdata(req_wdata), .in_reg(req_reg),
    .busy(busy), .done(done), .bad_done(illegal),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr),
    .upd_en(upd_en), .upd_sel(upd_sel), .upd_val(upd_val)
  );

  ptr_agu_ptrs #(.AW(AW), .NPTR(NPTR), .SW(SW)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_go), .ld_sel(ptr_load_sel), .ld_val(ptr_load_val),
    .upd_en(upd_en), .upd_sel(upd_sel), .upd_val(upd_val),
    .ptrs(ptrs)
  );

  assign rf_wdata = mem_rdata;
  assign ptr_x    = ptrs[0];
  assign ptr_y    = ptrs[1];
  assign ptr_z    = ptrs[2];

  // R4 R5 R11: pointers move only on completion or after an idle load
  ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptrs != $past(ptrs)) |-> (done || $past(ptr_load && !busy)));
  // R8
  illegal_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (ptrs == $past(ptrs)));
  // R10
  rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (done && !illegal));
  // R9
  mem_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> (busy && !done));
endmodule

// File: tb/ptr_agu_test.sv
module ptr_agu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0;
  logic [1:0] req_sel = 0;
  logic [2:0] req_mode = 0;
  logic [5:0] req_disp = 0;
  logic [15:0] req_imm = 0;
  logic [7:0] req_wdata = 0;
  logic [4:0] req_reg = 0;
  logic ptr_load = 0;
  logic [1:0] ptr_load_sel = 0;
  logic [15:0] ptr_load_val = 0;
  logic busy, done, illegal, mem_re, mem_we, rf_we;
  logic [15:0] mem_addr, ptr_x, ptr_y, ptr_z;
  logic [7:0] mem_wdata, rf_wdata;
  logic [7:0] mem_rdata = 0;
  logic [4:0] rf_waddr;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  ptr_agu uut (.*);

  function automatic int init_byte(int a);
    return ((a & 255) ^ ((a >> 8) & 255) ^ 8'h5A);
  endfunction

  // bench memory driven from the DUT ports
  int dmem [int];
  bit c_re, c_we;
  int c_addr, c_wd;
  always @(negedge clk) begin
    c_re = mem_re; c_we = mem_we; c_addr = int'(mem_addr); c_wd = int'(mem_wdata);
  end
  always @(posedge clk) begin
    if (c_we === 1'b1) dmem[c_addr] = c_wd;
    if (c_re === 1'b1) mem_rdata <= 8'(dmem.exists(c_addr) ? dmem[c_addr] : init_byte(c_addr));
  end

  // behavioural reference model
  int mmem [int];
  int mp [3];
  int mph = 0;
  bit m_st, m_ill, m_chg;
  int m_sel, m_addr, m_new, m_wd, m_reg, m_rd;
  string m_tag = "R3";
  bit started = 0;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mph = 0; mp[0] = 0; mp[1] = 0; mp[2] = 0;
    end else if (mph == 1) begin
      if (!m_ill) begin
        if (m_st) mmem[m_addr] = m_wd;
        else m_rd = mmem.exists(m_addr) ? mmem[m_addr] : init_byte(m_addr);
        if (m_chg) mp[m_sel] = m_new;
      end
      mph = 2;
    end else begin
      mph = 0;
      if (ptr_load) begin
        if (ptr_load_sel != 3) mp[ptr_load_sel] = int'(ptr_load_val);
      end else if (req_valid) begin
        int p, md;
        md = int'(req_mode);
        m_sel = int'(req_sel);
        p = (m_sel < 3) ? mp[m_sel] : 0;
        m_ill = (m_sel == 3) || (md > 4) || (md == 3 && m_sel == 0);
        m_st = req_store; m_wd = int'(req_wdata); m_reg = int'(req_reg);
        m_chg = 0; m_new = p;
        case (md)
          1: begin m_addr = p; m_new = (p + 1) % 65536; m_chg = 1; m_tag = "R4"; end
          2: begin m_new = (p + 65535) % 65536; m_addr = m_new; m_chg = 1; m_tag = "R5"; end
          3: begin m_addr = (p + int'(req_disp)) % 65536; m_tag = "R6"; end
          4: begin m_addr = int'(req_imm); m_tag = "R7"; end
          default: begin m_addr = p; m_tag = "R3"; end
        endcase
        if (m_ill) m_tag = "R8";
        mph = 1;
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      string tg;
      bit e_re, e_we, e_rf;
      tg = !rst_n ? "R1" : "R2";
      e_re = (mph == 1) && !m_ill && !m_st;
      e_we = (mph == 1) && !m_ill && m_st;
      e_rf = (mph == 2) && !m_ill && !m_st;
      chk(busy === (mph == 1), tg, "busy", int'(busy), int'(mph == 1));
      chk(done === (mph == 2), tg, "done", int'(done), int'(mph == 2));
      chk(illegal === ((mph == 2) && m_ill), !rst_n ? "R1" : "R8", "illegal", int'(illegal), int'((mph == 2) && m_ill));
      chk(mem_re === e_re, !rst_n ? "R1" : "R10", "mem_re", int'(mem_re), int'(e_re));
      chk(mem_we === e_we, !rst_n ? "R1" : "R9", "mem_we", int'(mem_we), int'(e_we));
      chk(rf_we === e_rf, !rst_n ? "R1" : "R10", "rf_we", int'(rf_we), int'(e_rf));
      if (e_re || e_we) chk(int'(mem_addr) == m_addr, m_tag, "mem_addr", int'(mem_addr), m_addr);
      if (e_we) chk(int'(mem_wdata) == m_wd, "R9", "mem_wdata", int'(mem_wdata), m_wd);
      if (e_rf) begin
        chk(int'(rf_waddr) == m_reg, "R10", "rf_waddr", int'(rf_waddr), m_reg);
        chk(int'(rf_wdata) == m_rd, "R10", "rf_wdata", int'(rf_wdata), m_rd);
      end
      tg = !rst_n ? "R1" : ((mph == 2) ? m_tag : "R11");
      chk(int'(ptr_x) == mp[0], tg, "ptr_x", int'(ptr_x), mp[0]);
      chk(int'(ptr_y) == mp[1], tg, "ptr_y", int'(ptr_y), mp[1]);
      chk(int'(ptr_z) == mp[2], tg, "ptr_z", int'(ptr_z), mp[2]);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear();
    req_valid = 0; ptr_load = 0;
  endtask

  task automatic pload(logic [1:0] s, logic [15:0] v);
    ptr_load = 1; ptr_load_sel = s; ptr_load_val = v; step(); clear();
  endtask

  task automatic xfer(bit st, logic [1:0] s, logic [2:0] m, logic [5:0] q,
                      logic [15:0] k, logic [7:0] wd, logic [4:0] rg);
    req_valid = 1; req_store = st; req_sel = s; req_mode = m;
    req_disp = q; req_imm = k; req_wdata = wd; req_reg = rg;
    step(); clear(); step();
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();                        // R1 checked during reset
    rst_n = 1; step();
    pload(2'd0, 16'h1000); pload(2'd1, 16'h2000); pload(2'd2, 16'hFFFF);
    pload(2'd3, 16'hDEAD);                    // R11: code 3 writes nothing
    xfer(1, 0, 0, 0, 0, 8'hAA, 0);            // R3 R9 store plain
    xfer(0, 0, 0, 0, 0, 0, 5'd7);             // R3 R10 load back
    xfer(1, 0, 1, 0, 0, 8'h11, 0);            // R4
    xfer(0, 1, 1, 0, 0, 0, 5'd3);             // R4
    xfer(0, 2, 1, 0, 0, 0, 5'd4);             // R4 wrap FFFF -> 0
    xfer(0, 0, 2, 0, 0, 0, 5'd5);             // R5
    xfer(1, 2, 2, 0, 0, 8'h77, 0);            // R5 wrap 0 -> FFFF
    xfer(0, 1, 3, 6'd63, 0, 0, 5'd9);         // R6 max offset
    pload(2'd2, 16'hFFFE);
    xfer(1, 2, 3, 6'd5, 0, 8'h42, 0);         // R6 wrap
    xfer(0, 2, 3, 6'd5, 0, 0, 5'd1);          // R6 read back
    xfer(0, 0, 3, 6'd4, 0, 0, 5'd2);          // R8 offset on X
    xfer(1, 3, 0, 0, 0, 8'h99, 0);            // R8 select 3
    xfer(0, 1, 3'd6, 0, 0, 0, 5'd2);          // R8 mode 6
    xfer(1, 1, 4, 0, 16'h1234, 8'h5C, 0);     // R7
    xfer(0, 0, 4, 0, 16'h1234, 0, 5'd31);     // R7
    // R2: request held through busy cycle
    req_valid = 1; req_store = 0; req_sel = 1; req_mode = 1; step(); step(); step(); clear(); step();
    // R11: load during busy ignored, load beats request
    req_valid = 1; req_sel = 0; req_mode = 0; step();
    req_valid = 0; ptr_load = 1; ptr_load_sel = 0; ptr_load_val = 16'h5555; step(); clear(); step();
    req_valid = 1; ptr_load = 1; ptr_load_sel = 1; ptr_load_val = 16'h0100; step(); clear(); step(); step();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      req_valid = ($urandom % 3) != 0;
      req_store = $urandom % 2;
      req_sel = 2'($urandom);
      req_mode = ($urandom % 8 < 6) ? 3'($urandom % 5) : 3'($urandom);
      req_disp = 6'($urandom);
      req_imm = 16'($urandom);
      req_wdata = 8'($urandom);
      req_reg = 5'($urandom);
      ptr_load = ($urandom % 10) == 0;
      ptr_load_sel = 2'($urandom);
      ptr_load_val = ($urandom % 2) ? 16'($urandom % 4) : 16'hFFFF - 16'($urandom % 4);
      step();
    end
    clear(); step(); step(); step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule